// File: doc/BRIEF.md
# Receive Descriptor Ring Prefetch Engine

This block sits between a receive packet path and host memory. It tracks a circular ring of 16-byte receive descriptors in host memory. The ring is given by a base address, a length in bytes and a software tail index. The engine owns a head index. Software moves the tail forward to hand descriptors over. The engine keeps a small on-chip count of descriptors that it has fetched but not yet used, and of descriptors that it has completed but not yet returned to memory.

Host traffic is grouped into bursts. A fetch burst goes out when too few unused descriptors remain on chip and enough hardware-owned descriptors wait in host memory. A write-back burst goes out when enough completed descriptors have built up. Thresholds are counted either in descriptors or in cache lines. Each burst is one request on a request/acknowledge command port carrying an address and a count. The packet path sees whether a descriptor is ready and its ring index. It completes descriptors one at a time and marks the last descriptor of each packet. Data movement and descriptor contents are handled elsewhere.

Top module: `rxdesc_prefetch`

## Requirements
- R1: The ring holds cfg_len/16 descriptors and is usable only when cfg_len is nonzero and a multiple of 128. With any other length no fetch or write-back request is ever raised.
- R2: Hardware owns ring indices from head up to, but not including, sw_tail, and no fetch reaches beyond sw_tail. When the fetch pointer equals sw_tail no fetch is raised.
- R3: A fetch request is raised when all of these hold: the unused on-chip count is below the prefetch threshold; the hardware-owned descriptors not yet fetched number at least the host threshold; and on-chip occupancy plus the host threshold does not exceed DEPTH. Its address is cfg_base + 16 × fetch pointer and its count is the host threshold. A prefetch threshold of 0 disables fetching.
- R4: When cfg_gran=1, thresholds count descriptors. When cfg_gran=0, each unit is one cache line of CL_BYTES/16 descriptors (4 by default). Converted thresholds saturate at DEPTH. A host or write-back threshold of 0 acts as 1.
- R5: A burst count is cut so that it does not cross the end of the ring. The fetch pointer and head each wrap to 0 when they reach the ring size.
- R6: When the number of completed descriptors waiting on chip reaches the write-back threshold, a write-back request of that count is raised at cfg_base + 16 × head. Bit i of wb_eop is the end-of-packet flag recorded for descriptor head+i, and bits at or above the count are 0. Each written-back descriptor is reported as done.
- R7: When cfg_gran=1, completed descriptors waiting on chip exist, and no unused descriptors remain on chip, all waiting descriptors are written back even below the threshold.
- R8: Head advances by wb_cnt only on the clock edge where wb_req and wb_ack are both high. A fetch acknowledge advances the fetch pointer and adds to the unused count.
- R9: At most one request is outstanding. It holds its address and count until acknowledged. When a write-back and a fetch are both due, the write-back goes first.
- R10: pkt_avail is high while unused descriptors are on chip, and pkt_idx gives the ring index of the oldest of them. A pkt_done pulse while pkt_avail is low is ignored.
- R11: After reset, head and the fetch pointer are 0, no request is raised and pkt_avail is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Ring base address in host memory |
| cfg_len | input | LEN_W | Ring length in bytes |
| sw_tail | input | LEN_W-4 | Software tail index |
| cfg_gran | input | 1 | Threshold unit: 1 = descriptors, 0 = cache lines |
| cfg_pthr | input | THR_W | Prefetch threshold |
| cfg_hthr | input | THR_W | Host threshold |
| cfg_wthr | input | THR_W | Write-back threshold |
| head_idx | output | LEN_W-4 | Hardware head index |
| fetch_req | output | 1 | Fetch burst request |
| fetch_addr | output | ADDR_W | Fetch burst start address |
| fetch_cnt | output | log2(DEPTH)+1 | Descriptors in fetch burst |
| fetch_ack | input | 1 | Fetch burst accepted |
| wb_req | output | 1 | Write-back burst request |
| wb_addr | output | ADDR_W | Write-back burst start address |
| wb_cnt | output | log2(DEPTH)+1 | Descriptors in write-back burst |
| wb_eop | output | DEPTH | End-of-packet flag per descriptor in burst |
| wb_ack | input | 1 | Write-back burst accepted |
| pkt_avail | output | 1 | An unused descriptor is ready on chip |
| pkt_idx | output | LEN_W-4 | Ring index of the oldest unused descriptor |
| pkt_done | input | 1 | Complete the oldest unused descriptor |
| pkt_eop | input | 1 | That descriptor ends a packet |

## Verification
A wrong head or fetch pointer shows at the ports within one request. The next fetch_addr or wb_addr lands at the wrong 16-byte offset. A wrong completed count shows as a write-back that comes a cycle early or late, or as a pkt_idx that is off by one straight after the next pkt_done. Wrong eop storage appears in wb_eop of the burst that covers the affected descriptor. Errors in wrap and split handling surface as a burst count that crosses the ring end, at the first request issued near the wrap point.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_FETCH = 2'd1,
      ARB_WB    = 2'd2
   } arb_state_e;

   // Advance a ring index by step, wrapping at ring size n.
   function automatic logic [31:0] ring_adv(input logic [31:0] idx,
                                            input logic [31:0] step,
                                            input logic [31:0] n);
      logic [31:0] s;
      s = idx + step;
      return (s >= n) ? (s - n) : s;
   endfunction

endpackage

// File: rtl/rxr_thr_conv.sv
module rxr_thr_conv #(
   parameter int THR_W   = 6,
   parameter int DEPTH   = 8,
   parameter int CL_DESC = 4
) (
   input  logic                     gran,
   input  logic [THR_W-1:0]         thr_in,
   output logic [$clog2(DEPTH):0]   thr_out
);
   localparam int DW1   = $clog2(DEPTH) + 1;
   localparam int CL_SH = $clog2(CL_DESC);
   localparam int EXT_W = THR_W + CL_SH + 1;

   logic [EXT_W-1:0] raw;
   logic [EXT_W-1:0] scaled;
   logic [EXT_W-1:0] sel;

   assign raw = {{(EXT_W-THR_W){1'b0}}, thr_in};

   generate
      if ((CL_DESC & (CL_DESC - 1)) == 0) begin : g_shift
         assign scaled = raw << CL_SH;
      end else begin : g_mult
         assign scaled = raw * EXT_W'(CL_DESC);
      end
   endgenerate

   assign sel     = gran ? raw : scaled;
   assign thr_out = (sel > EXT_W'(DEPTH)) ? DW1'(DEPTH) : sel[DW1-1:0];

endmodule

// File: rtl/rxr_ring_geom.sv
module rxr_ring_geom #(
   parameter int LEN_W = 16
) (
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [LEN_W-5:0]  head,
   input  logic [LEN_W-5:0]  fptr,
   input  logic [LEN_W-5:0]  tail,
   output logic              ring_ok,
   output logic [LEN_W-5:0]  n_ring,
   output logic [LEN_W-4:0]  host_av,
   output logic [LEN_W-4:0]  end_h,
   output logic [LEN_W-4:0]  end_f
);
   localparam int IDX_W = LEN_W - 4;

   logic [IDX_W:0] n_x, t_x, f_x, h_x;

   assign n_ring  = cfg_len[LEN_W-1:4];
   assign ring_ok = (cfg_len[6:0] == 7'd0) && (cfg_len != '0);

   assign n_x = {1'b0, n_ring};
   assign t_x = {1'b0, tail};
   assign f_x = {1'b0, fptr};
   assign h_x = {1'b0, head};

   // Hardware-owned descriptors still in host memory, not yet fetched.
   assign host_av = (t_x >= f_x) ? (t_x - f_x) : (t_x + n_x - f_x);
   assign end_h   = n_x - h_x;
   assign end_f   = n_x - f_x;

endmodule

// File: rtl/rxr_slot_track.sv
module rxr_slot_track #(
   parameter int IDX_W = 12,
   parameter int DEPTH = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [IDX_W-1:0]        head,
   input  logic [IDX_W-1:0]        n_ring,
   input  logic                    fetch_acc,
   input  logic [$clog2(DEPTH):0]  fetch_n,
   input  logic                    wb_acc,
   input  logic [$clog2(DEPTH):0]  wb_n,
   input  logic                    done,
   input  logic                    done_eop,
   output logic [$clog2(DEPTH):0]  unproc,
   output logic [$clog2(DEPTH):0]  compl,
   output logic [IDX_W-1:0]        oldest_idx,
   output logic [DEPTH-1:0]        eop_win
);
   localparam int DW  = $clog2(DEPTH);
   localparam int DW1 = DW + 1;

   logic [DEPTH-1:0] eop_mem;
   logic             done_ok;
   logic [IDX_W:0]   sum;
   logic [DW1-1:0]   f_add, w_sub, d_one;

   assign done_ok = done && (unproc != '0);
   assign f_add   = fetch_acc ? fetch_n : '0;
   assign w_sub   = wb_acc ? wb_n : '0;
   assign d_one   = {{(DW1-1){1'b0}}, done_ok};

   assign sum        = {1'b0, head} + {{(IDX_W+1-DW1){1'b0}}, compl};
   assign oldest_idx = (sum >= {1'b0, n_ring}) ? IDX_W'(sum - {1'b0, n_ring})
                                               : sum[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unproc  <= '0;
         compl   <= '0;
         eop_mem <= '0;
      end else begin
         unproc <= unproc + f_add - d_one;
         compl  <= compl + d_one - w_sub;
         if (done_ok) eop_mem[oldest_idx[DW-1:0]] <= done_eop;
      end
   end

   // Ring size is a multiple of DEPTH, so index modulo DEPTH names a slot.
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         eop_win[i] = eop_mem[head[DW-1:0] + DW'(i)];
      end
   end

   p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, unproc} + {1'b0, compl}) <= (DW1+1)'(DEPTH));

   p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && unproc == '0 && !wb_acc) |=> $stable(compl));

endmodule

// File: rtl/rxdesc_prefetch.sv
module rxdesc_prefetch #(
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 16,
   parameter int THR_W    = 6,
   parameter int DEPTH    = 8,
   parameter int CL_BYTES = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       cfg_base,
   input  logic [LEN_W-1:0]        cfg_len,
   input  logic [LEN_W-5:0]        sw_tail,
   input  logic                    cfg_gran,
   input  logic [THR_W-1:0]        cfg_pthr,
   input  logic [THR_W-1:0]        cfg_hthr,
   input  logic [THR_W-1:0]        cfg_wthr,
   output logic [LEN_W-5:0]        head_idx,
   output logic                    fetch_req,
   output logic [ADDR_W-1:0]       fetch_addr,
   output logic [$clog2(DEPTH):0]  fetch_cnt,
   input  logic                    fetch_ack,
   output logic                    wb_req,
   output logic [ADDR_W-1:0]       wb_addr,
   output logic [$clog2(DEPTH):0]  wb_cnt,
   output logic [DEPTH-1:0]        wb_eop,
   input  logic                    wb_ack,
   output logic                    pkt_avail,
   output logic [LEN_W-5:0]        pkt_idx,
   input  logic                    pkt_done,
   input  logic                    pkt_eop
);
   import rxr_pkg::*;

   localparam int IDX_W   = LEN_W - 4;
   localparam int DW1     = $clog2(DEPTH) + 1;
   localparam int CL_DESC = CL_BYTES / 16;
   localparam int NTHR    = 3;

   initial begin
      a_depth: assert (DEPTH >= 2 && DEPTH <= 8 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two from 2 to 8");
      a_len: assert (LEN_W >= 8) else $error("LEN_W too small");
      a_thr: assert (THR_W >= DW1) else $error("THR_W too small");
      a_cl: assert (CL_BYTES >= 16 && CL_BYTES % 16 == 0) else $error("CL_BYTES");
      a_addr: assert (ADDR_W >= LEN_W) else $error("ADDR_W too small");
   end

   arb_state_e       st;
   logic [IDX_W-1:0] head, fptr;

   // Threshold conversion, one converter per threshold.
   logic [THR_W-1:0] thr_raw [NTHR];
   logic [DW1-1:0]   thr_cv  [NTHR];
   assign thr_raw[0] = cfg_pthr;
   assign thr_raw[1] = cfg_hthr;
   assign thr_raw[2] = cfg_wthr;

   for (genvar g = 0; g < NTHR; g++) begin : g_thr
      rxr_thr_conv #(.THR_W(THR_W), .DEPTH(DEPTH), .CL_DESC(CL_DESC)) u_conv (
         .gran   (cfg_gran),
         .thr_in (thr_raw[g]),
         .thr_out(thr_cv[g])
      );
   end

   logic [DW1-1:0] pth_e, hth_e, wth_e;
   assign pth_e = thr_cv[0];
   assign hth_e = (thr_cv[1] == '0) ? DW1'(1) : thr_cv[1];
   assign wth_e = (thr_cv[2] == '0) ? DW1'(1) : thr_cv[2];

   // Ring geometry.
   logic             ring_ok;
   logic [IDX_W-1:0] n_ring;
   logic [IDX_W:0]   host_av, end_h, end_f;

   rxr_ring_geom #(.LEN_W(LEN_W)) u_geom (
      .cfg_len(cfg_len), .head(head), .fptr(fptr), .tail(sw_tail),
      .ring_ok(ring_ok), .n_ring(n_ring), .host_av(host_av),
      .end_h(end_h), .end_f(end_f)
   );

   // On-chip slot accounting.
   logic             fetch_acc, wb_acc;
   logic [DW1-1:0]   unproc, compl;
   logic [DEPTH-1:0] eop_win;

   assign fetch_acc = fetch_req && fetch_ack;
   assign wb_acc    = wb_req && wb_ack;

   rxr_slot_track #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_slots (
      .clk(clk), .rst_n(rst_n), .head(head), .n_ring(n_ring),
      .fetch_acc(fetch_acc), .fetch_n(fetch_cnt),
      .wb_acc(wb_acc), .wb_n(wb_cnt),
      .done(pkt_done), .done_eop(pkt_eop),
      .unproc(unproc), .compl(compl), .oldest_idx(pkt_idx), .eop_win(eop_win)
   );

   // Burst decisions.
   logic              wb_hit, wb_flush, want_wb, want_f;
   logic [DW1-1:0]    wb_pick, wb_n_c, f_n_c;
   logic [DEPTH-1:0]  cnt_mask;
   logic [IDX_W:0]    wb_pick_x, hth_x;
   logic [31:0]       head_adv, fptr_adv;

   always_comb begin
      wb_hit    = compl >= wth_e;
      wb_flush  = cfg_gran && (compl != '0) && (unproc == '0);
      want_wb   = ring_ok && (wb_hit || wb_flush);
      wb_pick   = wb_hit ? wth_e : compl;
      wb_pick_x = {{(IDX_W+1-DW1){1'b0}}, wb_pick};
      wb_n_c    = (end_h < wb_pick_x) ? end_h[DW1-1:0] : wb_pick;

      hth_x  = {{(IDX_W+1-DW1){1'b0}}, hth_e};
      want_f = ring_ok && (unproc < pth_e) && (host_av >= hth_x) &&
               (({1'b0, unproc} + {1'b0, compl} + {1'b0, hth_e}) <= (DW1+1)'(DEPTH));
      f_n_c  = (end_f < hth_x) ? end_f[DW1-1:0] : hth_e;

      for (int i = 0; i < DEPTH; i++) cnt_mask[i] = DW1'(i) < wb_n_c;

      head_adv = ring_adv(32'(head), 32'(wb_cnt), 32'(n_ring));
      fptr_adv = ring_adv(32'(fptr), 32'(fetch_cnt), 32'(n_ring));
   end

   function automatic logic [ADDR_W-1:0] idx_off(input logic [IDX_W-1:0] idx);
      return {{(ADDR_W-IDX_W-4){1'b0}}, idx, 4'b0000};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ARB_IDLE;
         head       <= '0;
         fptr       <= '0;
         fetch_req  <= 1'b0;
         fetch_addr <= '0;
         fetch_cnt  <= '0;
         wb_req     <= 1'b0;
         wb_addr    <= '0;
         wb_cnt     <= '0;
         wb_eop     <= '0;
      end else begin
         case (st)
            ARB_IDLE: begin
               if (want_wb) begin
                  wb_req  <= 1'b1;
                  wb_addr <= cfg_base + idx_off(head);
                  wb_cnt  <= wb_n_c;
                  wb_eop  <= eop_win & cnt_mask;
                  st      <= ARB_WB;
               end else if (want_f) begin
                  fetch_req  <= 1'b1;
                  fetch_addr <= cfg_base + idx_off(fptr);
                  fetch_cnt  <= f_n_c;
                  st         <= ARB_FETCH;
               end
            end
            ARB_FETCH: begin
               if (fetch_ack) begin
                  fetch_req <= 1'b0;
                  fptr      <= fptr_adv[IDX_W-1:0];
                  st        <= ARB_IDLE;
               end
            end
            ARB_WB: begin
               if (wb_ack) begin
                  wb_req <= 1'b0;
                  head   <= head_adv[IDX_W-1:0];
                  st     <= ARB_IDLE;
               end
            end
            default: st <= ARB_IDLE;
         endcase
      end
   end

   assign head_idx  = head;
   assign pkt_avail = unproc != '0;

   p_one_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fetch_req, wb_req}));

   p_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr) && $stable(fetch_cnt)));

   p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_cnt)));

   p_head_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_req && wb_ack) |=> $stable(head_idx));

   p_bad_ring_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ARB_IDLE && !ring_ok) |=> (!fetch_req && !wb_req));

   p_nonzero_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req |-> fetch_cnt != '0) and (wb_req |-> wb_cnt != '0));

endmodule

// File: tb/tb_rxdesc_prefetch.sv
module tb_rxdesc_prefetch;

   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;
   localparam int THR_W  = 6;
   localparam int DEPTH  = 8;
   localparam logic [31:0] B = 32'h1000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [31:0]       cfg_base = B;
   logic [15:0]       cfg_len = 16'd128;
   logic [11:0]       sw_tail = '0;
   logic              cfg_gran = 1'b1;
   logic [5:0]        cfg_pthr = '0, cfg_hthr = '0, cfg_wthr = 6'd2;
   logic [11:0]       head_idx, pkt_idx;
   logic              fetch_req, fetch_ack = 1'b0, wb_req, wb_ack = 1'b0;
   logic [31:0]       fetch_addr, wb_addr;
   logic [3:0]        fetch_cnt, wb_cnt;
   logic [7:0]        wb_eop;
   logic              pkt_avail, pkt_done = 1'b0, pkt_eop = 1'b0;

   int checks = 0;
   int errors = 0;
   bit ended  = 0;

   always #5 clk = ~clk;

   rxdesc_prefetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .THR_W(THR_W), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
      .sw_tail(sw_tail), .cfg_gran(cfg_gran), .cfg_pthr(cfg_pthr),
      .cfg_hthr(cfg_hthr), .cfg_wthr(cfg_wthr), .head_idx(head_idx),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_cnt(fetch_cnt),
      .fetch_ack(fetch_ack), .wb_req(wb_req), .wb_addr(wb_addr),
      .wb_cnt(wb_cnt), .wb_eop(wb_eop), .wb_ack(wb_ack),
      .pkt_avail(pkt_avail), .pkt_idx(pkt_idx), .pkt_done(pkt_done),
      .pkt_eop(pkt_eop)
   );

   // {len16, gran1, pthr6, hthr6, tail12, exp_req1, exp_cnt4}
   localparam int NV = 10;
   localparam logic [45:0] VEC [NV] = '{
      {16'd128, 1'b1, 6'd4, 6'd4,  12'd6,  1'b1, 4'd4},
      {16'd128, 1'b1, 6'd4, 6'd4,  12'd3,  1'b0, 4'd0},
      {16'd256, 1'b0, 6'd1, 6'd1,  12'd10, 1'b1, 4'd4},
      {16'd100, 1'b1, 6'd4, 6'd1,  12'd5,  1'b0, 4'd0},
      {16'd128, 1'b1, 6'd0, 6'd1,  12'd5,  1'b0, 4'd0},
      {16'd256, 1'b1, 6'd8, 6'd20, 12'd12, 1'b1, 4'd8},
      {16'd384, 1'b0, 6'd2, 6'd2,  12'd20, 1'b1, 4'd8},
      {16'd128, 1'b1, 6'd4, 6'd2,  12'd0,  1'b0, 4'd0},
      {16'd192, 1'b1, 6'd4, 6'd1,  12'd5,  1'b0, 4'd0},
      {16'd128, 1'b1, 6'd4, 6'd2,  12'd7,  1'b1, 4'd2}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_fetch(output bit seen);
      seen = 0;
      for (int k = 0; k < 8; k++) begin
         if (fetch_req) begin seen = 1; return; end
         @(negedge clk);
      end
   endtask

   task automatic wait_wb(output bit seen);
      seen = 0;
      for (int k = 0; k < 8; k++) begin
         if (wb_req) begin seen = 1; return; end
         @(negedge clk);
      end
   endtask

   task automatic quiet(input int n, output int hits);
      hits = 0;
      for (int k = 0; k < n; k++) begin
         if (fetch_req || wb_req) hits++;
         @(negedge clk);
      end
   endtask

   task automatic ack_fetch();
      fetch_ack = 1'b1;
      @(negedge clk);
      fetch_ack = 1'b0;
   endtask

   task automatic ack_wb();
      wb_ack = 1'b1;
      @(negedge clk);
      wb_ack = 1'b0;
   endtask

   task automatic do_done(input logic e);
      pkt_done = 1'b1;
      pkt_eop  = e;
      @(negedge clk);
      pkt_done = 1'b0;
      pkt_eop  = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      bit seen;
      int hits;

      // R11: reset state, sampled while reset is held.
      @(negedge clk);
      chk("R11 head", 64'(head_idx), 64'd0);
      chk("R11 fetch_req", 64'(fetch_req), 64'd0);
      chk("R11 wb_req", 64'(wb_req), 64'd0);
      chk("R11 pkt_avail", 64'(pkt_avail), 64'd0);

      // Table walk: R1, R2, R3, R4 first-fetch decisions.
      for (int v = 0; v < NV; v++) begin
         cfg_len  = VEC[v][45:30];
         cfg_gran = VEC[v][29];
         cfg_pthr = VEC[v][28:23];
         cfg_hthr = VEC[v][22:17];
         sw_tail  = VEC[v][16:5];
         cfg_wthr = 6'd2;
         do_reset();
         wait_fetch(seen);
         chk($sformatf("R3/R4 vec%0d fetch raised (R1 R2)", v), 64'(seen), 64'(VEC[v][4]));
         if (VEC[v][4]) begin
            chk($sformatf("R3 vec%0d cnt", v), 64'(fetch_cnt), 64'(VEC[v][3:0]));
            chk($sformatf("R3 vec%0d addr", v), 64'(fetch_addr), 64'(B));
         end else begin
            chk($sformatf("R1 vec%0d no wb", v), 64'(wb_req), 64'd0);
         end
      end

      // Directed: ring of 8, thresholds in descriptors.
      cfg_len = 16'd128; cfg_gran = 1'b1;
      cfg_pthr = 6'd4; cfg_hthr = 6'd4; cfg_wthr = 6'd2; sw_tail = 12'd6;
      do_reset();
      wait_fetch(seen);
      chk("R3 first fetch", 64'(seen), 64'd1);
      chk("R3 first cnt", 64'(fetch_cnt), 64'd4);
      ack_fetch();
      chk("R10 avail", 64'(pkt_avail), 64'd1);
      chk("R10 idx0", 64'(pkt_idx), 64'd0);
      chk("R3 no refetch at threshold", 64'(fetch_req), 64'd0);

      do_done(1'b0);
      chk("R10 idx1", 64'(pkt_idx), 64'd1);
      do_done(1'b1);
      wait_wb(seen);
      chk("R6 wb raised", 64'(seen), 64'd1);
      chk("R6 wb cnt", 64'(wb_cnt), 64'd2);
      chk("R6 wb addr", 64'(wb_addr), 64'(B));
      chk("R6 wb eop", 64'(wb_eop), 64'h02);
      chk("R8 head before ack", 64'(head_idx), 64'd0);
      repeat (3) @(negedge clk);
      chk("R9 wb held", 64'(wb_req), 64'd1);
      chk("R9 wb cnt held", 64'(wb_cnt), 64'd2);
      ack_wb();
      chk("R8 head after ack", 64'(head_idx), 64'd2);
      chk("R10 idx after wb", 64'(pkt_idx), 64'd2);

      quiet(5, hits);
      chk("R2 no fetch past tail", 64'(hits), 64'd0);

      sw_tail = 12'd2;
      wait_fetch(seen);
      chk("R2 fetch after tail wrap", 64'(seen), 64'd1);
      chk("R5 fetch cnt at end", 64'(fetch_cnt), 64'd4);
      chk("R5 fetch addr", 64'(fetch_addr), 64'(B + 32'd64));
      ack_fetch();

      cfg_pthr = 6'd3; cfg_hthr = 6'd2;
      do_done(1'b1);
      do_done(1'b0);
      wait_wb(seen);
      chk("R6 second wb addr", 64'(wb_addr), 64'(B + 32'd32));
      chk("R6 second wb eop", 64'(wb_eop), 64'h01);
      ack_wb();
      chk("R8 head 4", 64'(head_idx), 64'd4);

      do_done(1'b0);
      do_done(1'b1);
      wait_wb(seen);
      chk("R9 wb first", 64'(seen), 64'd1);
      chk("R9 fetch waits", 64'(fetch_req), 64'd0);
      chk("R9 wb addr", 64'(wb_addr), 64'(B + 32'd64));
      chk("R6 third wb eop", 64'(wb_eop), 64'h02);
      ack_wb();
      wait_fetch(seen);
      chk("R9 fetch after wb", 64'(seen), 64'd1);
      chk("R5 fetch wrapped addr", 64'(fetch_addr), 64'(B));
      chk("R3 fetch cnt hthr", 64'(fetch_cnt), 64'd2);
      ack_fetch();

      // R7 flush with threshold above the waiting count.
      cfg_wthr = 6'd8;
      do_done(1'b1);
      do_done(1'b1);
      do_done(1'b0);
      do_done(1'b1);
      wait_wb(seen);
      chk("R7 flush raised", 64'(seen), 64'd1);
      chk("R5 flush split cnt", 64'(wb_cnt), 64'd2);
      chk("R7 flush addr", 64'(wb_addr), 64'(B + 32'd96));
      chk("R7 flush eop", 64'(wb_eop), 64'h03);
      ack_wb();
      chk("R5 head wrapped", 64'(head_idx), 64'd0);
      wait_wb(seen);
      chk("R7 second flush", 64'(seen), 64'd1);
      chk("R7 second flush addr", 64'(wb_addr), 64'(B));
      chk("R7 second flush eop", 64'(wb_eop), 64'h02);
      ack_wb();
      chk("R8 head 2", 64'(head_idx), 64'd2);
      chk("R10 no avail", 64'(pkt_avail), 64'd0);

      // R10: done with nothing on chip is ignored.
      do_done(1'b1);
      quiet(6, hits);
      chk("R10 ignored done no req", 64'(hits), 64'd0);
      chk("R10 ignored done head", 64'(head_idx), 64'd2);
      chk("R10 ignored done avail", 64'(pkt_avail), 64'd0);

      finish_run();
   end

endmodule